// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block brings an asynchronous DRAM out of power-up and then keeps its contents alive. After reset it leaves the strobes idle for a long settling pause. It then runs a fixed burst of refresh cycles in which the column strobe falls before the row strobe, so the device picks the row from its own internal counter. When the burst is over it raises `init_done`. The access controller beside it must not start any access while that flag is low.

After start-up an interval timer marks each point at which one more refresh is owed. A small saturating counter keeps track of the refreshes owed but not yet done. While that count is non-zero, the block requests the strobe bus. It starts a cycle only after the access controller grants the bus, and it drives row strobe, column strobe and write enable until that cycle has finished its precharge. Write enable stays high at all times, so that no refresh cycle can be taken as a test-mode entry. All strobe timing is counted in clock cycles of the host clock.

Top module: `dram_refresh_seq`

## Requirements
- R1: Out of reset, `ras_n`, `cas_n` and `we_n` are high and `bus_req`, `init_done` and `pend_level` are zero. The first column strobe falls in clock cycle PAUSE_CYC+1 after reset is released, and not before.
- R2: Right after the pause the block runs exactly INIT_CYCLES refresh cycles, with one idle cycle between them. `init_done` rises in the same cycle in which the last of these cycles leaves its precharge.
- R3: In every refresh cycle `cas_n` is low for CSR_CYC cycles before `ras_n` falls. `ras_n` then stays low for RAS_LOW_CYC cycles, with `cas_n` still low, and both strobes rise together.
- R4: `we_n` is never driven low.
- R5: Between a rise of `ras_n` and its next fall there are at least PRECH_CYC cycles with `ras_n` high.
- R6: From the rise of `init_done`, one refresh is added to `pend_level` every INTERVAL_CYC cycles. The first increment appears exactly INTERVAL_CYC cycles after the rise. The count saturates at PEND_MAX.
- R7: After initialization, `bus_req` is high exactly while `pend_level` is non-zero. A refresh cycle starts only after `bus_gnt` has been seen high at a clock edge while the block is idle. With `bus_gnt` held low, no cycle starts.
- R8: Each refresh cycle that starts after initialization takes one off `pend_level` when its precharge ends. If an interval increment falls in that same cycle, the count is left unchanged.
- R9: `bus_gnt` has no effect before `init_done`. Holding it high during the pause does not start a cycle early, and holding it low during the start-up burst does not delay that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_gnt | input | 1 | Strobe bus granted by the access controller |
| bus_req | output | 1 | Strobe bus wanted for refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |
| init_done | output | 1 | Start-up sequence finished; accesses allowed |
| pend_level | output | $clog2(PEND_MAX+1) | Refreshes owed but not yet completed |

## Verification
An interval increment and the end of a refresh precharge can land on the same clock edge. When they do, the owed count has to stay where it was. The bench forces this collision on purpose. It leaves the count at one with the grant withheld, then works out the next interval edge from the measured rise of `init_done`. It grants the bus for a single cycle, exactly one full refresh length before that edge. `pend_level` must read the same value just before the edge, at the edge and just after it. A running model of the count, fed only by the port activity, also checks every other edge for the whole run.

// File: rtl/ref_seq_pkg.sv
package ref_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_CSETUP = 2'd1,
    PH_RLOW   = 2'd2,
    PH_PRECH  = 2'd3
  } ref_phase_t;

  // next owed-refresh count: +1 on tick, -1 on completion, clamp to [0,cap]
  function automatic int sat_step(int cur, logic inc, logic dec, int cap);
    int n;
    n = cur + (inc ? 1 : 0) - (dec ? 1 : 0);
    if (n > cap) n = cap;
    if (n < 0)   n = 0;
    return n;
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int cnt_width(int limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/ref_tick_timer.sv
module ref_tick_timer
  import ref_seq_pkg::*;
#(
  parameter int LIMIT    = 3900,
  parameter bit ONE_SHOT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic hit
);
  localparam int CW = cnt_width(LIMIT);

  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end = (cnt == CW'(LIMIT - 1));

  generate
    if (ONE_SHOT) begin : g_sticky
      logic hit_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt   <= '0;
          hit_q <= 1'b0;
        end else if (en && !hit_q) begin
          if (at_end) hit_q <= 1'b1;
          else        cnt   <= cnt + CW'(1);
        end
      end
      assign hit = hit_q;
      AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> hit); // R1
    end else begin : g_wrap
      always_ff @(posedge clk) begin
        if (!rst_n)  cnt <= '0;
        else if (en) cnt <= at_end ? '0 : cnt + CW'(1);
      end
      assign hit = en && at_end;
      AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && LIMIT > 1) |=> !hit); // R6
    end
  endgenerate

endmodule

// File: rtl/ref_pend_ctr.sv
module ref_pend_ctr
  import ref_seq_pkg::*;
#(
  parameter int CAP = 8,
  parameter int W   = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] level
);
  logic [W-1:0] level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= W'(sat_step(int'(level_q), inc, dec, CAP));
  end

  assign level = level_q;

  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level_q) <= CAP); // R6
  AST_CAP_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(level_q) == CAP && inc && !dec) |=> int'(level_q) == CAP); // R6
  AST_BOTH_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> $stable(level_q)); // R8

endmodule

// File: rtl/ref_strobe_fsm.sv
module ref_strobe_fsm
  import ref_seq_pkg::*;
#(
  parameter int CSR_CYC     = 3,
  parameter int RAS_LOW_CYC = 15,
  parameter int PRECH_CYC   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic ras_n,
  output logic cas_n,
  output logic done
);
  localparam int MAXC = max3(CSR_CYC, RAS_LOW_CYC, PRECH_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  ref_phase_t    st, st_nxt;
  logic [CW-1:0] cnt, cnt_nxt;

  always_comb begin
    st_nxt  = st;
    cnt_nxt = cnt + CW'(1);
    done    = 1'b0;
    unique case (st)
      PH_IDLE: begin
        cnt_nxt = '0;
        if (start) st_nxt = PH_CSETUP;
      end
      PH_CSETUP: if (cnt == CW'(CSR_CYC - 1)) begin
        st_nxt  = PH_RLOW;
        cnt_nxt = '0;
      end
      PH_RLOW: if (cnt == CW'(RAS_LOW_CYC - 1)) begin
        st_nxt  = PH_PRECH;
        cnt_nxt = '0;
      end
      PH_PRECH: if (cnt == CW'(PRECH_CYC - 1)) begin
        st_nxt  = PH_IDLE;
        cnt_nxt = '0;
        done    = 1'b1;
      end
      default: st_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= PH_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_nxt;
      cnt <= cnt_nxt;
    end
  end

  assign busy  = (st != PH_IDLE);
  assign ras_n = (st != PH_RLOW);
  assign cas_n = !((st == PH_CSETUP) || (st == PH_RLOW));

  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n))); // R3
  AST_STROBES_RISE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> $rose(ras_n)); // R3
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R8

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import ref_seq_pkg::*;
#(
  parameter int PAUSE_CYC    = 50000,
  parameter int INIT_CYCLES  = 8,
  parameter int INTERVAL_CYC = 3900,
  parameter int PEND_MAX     = 8,
  parameter int CSR_CYC      = 3,
  parameter int RAS_LOW_CYC  = 15,
  parameter int PRECH_CYC    = 10,
  localparam int PW          = $clog2(PEND_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_gnt,
  output logic          bus_req,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic          init_done,
  output logic [PW-1:0] pend_level
);
  localparam int IW = cnt_width(INIT_CYCLES);

  // named internal events
  logic          pause_over;
  logic          interval_tick;
  logic          cyc_start;
  logic          cyc_done;
  logic          busy;
  logic          want;
  logic          owed_dec;
  logic          init_q;
  logic [IW-1:0] init_cnt;

  ref_tick_timer #(.LIMIT(PAUSE_CYC), .ONE_SHOT(1'b1)) u_pause (
    .clk(clk), .rst_n(rst_n), .en(1'b1), .hit(pause_over));

  ref_tick_timer #(.LIMIT(INTERVAL_CYC), .ONE_SHOT(1'b0)) u_interval (
    .clk(clk), .rst_n(rst_n), .en(init_q), .hit(interval_tick));

  assign want      = pause_over && (!init_q || (pend_level != '0));
  assign cyc_start = !busy && want && (!init_q || bus_gnt);
  assign owed_dec  = cyc_done && init_q;

  ref_pend_ctr #(.CAP(PEND_MAX), .W(PW)) u_pend (
    .clk(clk), .rst_n(rst_n), .inc(interval_tick), .dec(owed_dec),
    .level(pend_level));

  ref_strobe_fsm #(.CSR_CYC(CSR_CYC), .RAS_LOW_CYC(RAS_LOW_CYC),
                   .PRECH_CYC(PRECH_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(cyc_start), .busy(busy),
    .ras_n(ras_n), .cas_n(cas_n), .done(cyc_done));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q   <= 1'b0;
      init_cnt <= '0;
    end else if (cyc_done && !init_q) begin
      if (init_cnt == IW'(INIT_CYCLES - 1)) init_q   <= 1'b1;
      else                                  init_cnt <= init_cnt + IW'(1);
    end
  end

  assign init_done = init_q;
  assign bus_req   = busy || want;
  assign we_n      = 1'b1;

  // run-length observers for strobe width checks
  logic [15:0] hi_run, lo_run;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run <= 16'(PRECH_CYC);
      lo_run <= '0;
    end else begin
      hi_run <= ras_n  ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 16'd1) : '0;
      lo_run <= !ras_n ? ((lo_run == 16'hFFFF) ? lo_run : lo_run + 16'd1) : '0;
    end
  end

  AST_QUIET_IN_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_over |-> (ras_n && cas_n && !bus_req)); // R1
  AST_RAS_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (int'(lo_run) >= RAS_LOW_CYC - 1)); // R3
  AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (int'(hi_run) >= PRECH_CYC)); // R5
  AST_GRANT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && $fell(cas_n)) |-> $past(bus_gnt)); // R7
  AST_REQ_WHILE_OWED: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && pend_level != '0) |-> bus_req); // R7
  AST_INIT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R2

endmodule

// File: tb/sim_dram_refresh_seq.sv
module sim_dram_refresh_seq;
  localparam int P  = 40;
  localparam int NI = 8;
  localparam int I  = 80;
  localparam int PM = 8;
  localparam int CS = 3;
  localparam int RL = 15;
  localparam int RP = 10;
  localparam int L  = CS + RL + RP;
  localparam int PW = $clog2(PM + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_gnt = 1'b0;
  logic bus_req, ras_n, cas_n, we_n, init_done;
  logic [PW-1:0] pend_level;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(P), .INIT_CYCLES(NI), .INTERVAL_CYC(I), .PEND_MAX(PM),
    .CSR_CYC(CS), .RAS_LOW_CYC(RL), .PRECH_CYC(RP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .bus_req(bus_req),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .init_done(init_done),
    .pend_level(pend_level));

  // ---------------- port observer and owed-count model ----------------
  int cyc = 0;
  logic g_last = 1'b0;
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
    g_last <= bus_gnt;
  end

  int rcount = 0, first_cas = -1, n0 = -1;
  int cpre = 0, csr_last = -1, rl = 0, rl_last = -1, hr = 1000, min_hr = 1000;
  int we_bad = 0, cas_early = 0, cas_late = 0, gnt_bad = 0, mism = 0, pm = 0;
  bit after_init = 1'b0, prev_ras = 1'b1, prev_cas = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!we_n) we_bad++;
      if (prev_cas && !cas_n) begin
        if (first_cas < 0) first_cas = cyc;
        if (init_done && !g_last) gnt_bad++;
      end
      if (prev_ras && !ras_n) begin
        rcount++;
        csr_last = cpre;
        if (hr < min_hr) min_hr = hr;
        after_init = init_done;
      end
      if (!prev_ras && ras_n) begin
        rl_last = rl;
        if (!cas_n) cas_late++;
      end
      if (cas_n) cpre = 0; else if (ras_n) cpre++;
      if (!ras_n) begin
        rl = prev_ras ? 1 : rl + 1;
        if (cas_n) cas_early++;
      end
      if (ras_n) hr = prev_ras ? hr + 1 : 1;
      if (init_done && n0 < 0) n0 = cyc;
      if (n0 >= 0 && cyc > n0) begin
        int inc, dec;
        inc = ((cyc - n0) % I == 0) ? 1 : 0;
        dec = (ras_n && hr == RP + 1 && after_init) ? 1 : 0;
        pm = pm + inc - dec;
        if (pm > PM) pm = PM;
        if (pm < 0) pm = 0;
        if (int'(pend_level) != pm) mism++;
      end
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_min(input string req, input string what, input int act, input int lo);
    checks++;
    if (act < lo) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected>=%0d", req, what, act, lo);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_cyc(input int target);
    while (cyc < target) step();
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_and_pause();
    int early;
    repeat (4) step();
    chk("R1", "ras_n in reset", int'(ras_n), 1);
    chk("R1", "cas_n in reset", int'(cas_n), 1);
    chk("R1", "we_n in reset", int'(we_n), 1);
    chk("R1", "bus_req in reset", int'(bus_req), 0);
    chk("R1", "init_done in reset", int'(init_done), 0);
    chk("R1", "pend_level in reset", int'(pend_level), 0);
    rst_n = 1'b1;
    bus_gnt = 1'b1;   // R9: grant during pause must not matter
    early = 0;
    while (cyc < P) begin
      step();
      if (!cas_n || !ras_n) early++;
    end
    chk("R1", "strobe activity during pause", early, 0);
  endtask

  task automatic t_init_burst();
    wait_cyc(30);
    bus_gnt = 1'b0;   // R9: burst must proceed without a grant
    while (n0 < 0 && cyc < 2000) step();
    chk("R1", "cycle of first cas_n fall", first_cas, P + 1);
    chk("R2", "cycle of init_done rise", n0, P + 1 + (NI - 1) * (L + 1) + L);
    chk("R9", "start-up cycles without grant", rcount, NI);
    step();
    chk("R7", "bus_req idle after init", int'(bus_req), 0);
  endtask

  task automatic t_owed_and_cap();
    wait_cyc(n0 + I - 1);
    chk("R6", "pend_level before first interval", int'(pend_level), 0);
    step();
    chk("R6", "pend_level at first interval", int'(pend_level), 1);
    chk("R7", "bus_req with refresh owed", int'(bus_req), 1);
    wait_cyc(n0 + 9 * I + 1);
    chk("R6", "pend_level saturated", int'(pend_level), PM);
    chk("R7", "no cycle while grant withheld", rcount, NI);
    chk("R7", "cas_n idle while grant withheld", int'(cas_n), 1);
  endtask

  task automatic t_drain();
    int rc0, lim;
    rc0 = rcount;
    bus_gnt = 1'b1;
    lim = cyc + 3000;
    while (pend_level != '0 && cyc < lim) step();
    bus_gnt = 1'b0;
    chk("R8", "owed count drained", int'(pend_level), 0);
    chk_min("R8", "refreshes during drain", rcount - rc0, PM);
    chk("R7", "bus_req dropped when nothing owed", int'(bus_req), 0);
  endtask

  task automatic t_collision();
    int t1, t2, rc0;
    t1 = n0 + ((cyc - n0) / I + 1) * I;
    if (t1 < cyc + 2) t1 += I;
    t2 = t1 + I;
    wait_cyc(t1);
    chk("R6", "owed count after one interval", int'(pend_level), 1);
    rc0 = rcount;
    wait_cyc(t2 - L - 1);
    bus_gnt = 1'b1;
    step();
    bus_gnt = 1'b0;
    wait_cyc(t2 - 1);
    chk("R8", "owed count before collision", int'(pend_level), 1);
    step();
    chk("R8", "owed count at tick+completion edge", int'(pend_level), 1);
    step();
    chk("R8", "owed count after collision", int'(pend_level), 1);
    chk("R7", "single-cycle grant gave one refresh", rcount - rc0, 1);
    chk("R7", "bus_req still high", int'(bus_req), 1);
  endtask

  task automatic t_summary_checks();
    chk("R3", "cas_n lead before ras_n fall", csr_last, CS);
    chk("R3", "ras_n low length", rl_last, RL);
    chk("R3", "cas_n rose before ras_n", cas_early, 0);
    chk("R3", "cas_n stayed low after ras_n rose", cas_late, 0);
    chk("R4", "we_n low samples", we_bad, 0);
    chk_min("R5", "shortest ras_n high stretch", min_hr, RP);
    chk("R7", "cycles started without grant", gnt_bad, 0);
    chk("R8", "owed-count model mismatches", mism, 0);
  endtask

  initial begin
    t_reset_and_pause();
    t_init_burst();
    t_owed_and_cap();
    t_drain();
    t_collision();
    t_summary_checks();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule